// File: doc/BRIEF.md
# 8b/10b Line Encoder with Idle Fill

This block turns a stream of bytes into 10-bit line code words for a serial link, using the standard 8b/10b code. Each offered byte carries a flag that marks it as a control character or a data character. The encoder splits the byte into a 5-bit and a 3-bit part and codes them through a 6-bit and a 4-bit sub-block. It tracks the running disparity so that the line stays DC balanced. It checks control characters against the legal set and flags the bad ones.

When no byte is offered and idle fill is selected, the encoder sends the K28.5 comma. A caller can replace the stored disparity with its own value for a given word. This lets two encoders run side by side: one takes the chain disparity of the other. A build parameter selects a short pipeline of one cycle or a long one of three cycles, with registered inputs and outputs.

Disparity is coded as 0 for negative and 1 for positive throughout.

Top module: `enc8b10b_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `code_out` = 0, `code_valid` = 0, `ctrl_err` = 0 and `disp_out` = 0. The stored running disparity becomes negative (0). Reset is synchronous.
- R2: A data byte (`in_en`=1, `in_ctrl`=0) with bits [4:0] = x and [7:5] = y is coded as the 6-bit code of D.x followed by the 4-bit code of D.y. `code_out[9:4]` carries abcdei with a in bit 9, and `code_out[3:0]` carries fghj with j in bit 0.
- R3: Each sub-block takes the negative-disparity form when the disparity entering it is negative. Otherwise it takes the complemented form, for unbalanced codes and for the D.7 (6-bit) and D.y.3 (4-bit) codes. An unbalanced sub-block flips the disparity. D.x.7 uses the alternate 0111/1000 form for x = 17, 18, 20 at negative disparity and for x = 11, 13, 14 at positive disparity.
- R4: The legal control characters are K28.0 to K28.7 and K23.7, K27.7, K29.7, K30.7, that is bytes with x = 28, or bytes 0xF7, 0xFB, 0xFD, 0xFE. They are coded as control codes (K28 six-bit block 001111/110000, and the control 4-bit column).
- R5: When `in_en`=1 and `in_ctrl`=1 with an illegal byte, `ctrl_err` is 1 alongside that word. The word is coded as the data character of the same byte and `code_valid` is 1.
- R6: When `in_en`=0 and `idle_fill`=1, the word is K28.5. It is 10'h0FA at negative disparity and 10'h305 at positive disparity, with `code_valid`=1 and `ctrl_err`=0.
- R7: When `in_en`=0 and `idle_fill`=0, `code_valid`=0, `code_out`=0 and `ctrl_err`=0, and the stored disparity does not change.
- R8: When `ext_disp_sel`=1, the word is coded from `ext_disp` as its starting disparity. The disparity after that word becomes the stored disparity.
- R9: `disp_out` is the stored running disparity after the word on `code_out`. When no word is on `code_out`, it is the held disparity.
- R10: `disp_chain` is combinational: it gives the disparity after the word in the coding stage, or the starting disparity when that stage holds no word. With LONG_PIPE=0 it follows the inputs of the same cycle; with LONG_PIPE=1 it follows those of the previous cycle.
- R11: With LONG_PIPE=1, the result of a request shows on the outputs three rising edges after it is presented. With LONG_PIPE=0, it shows after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_ctrl | input | 1 | 1 = byte is a control character, 0 = data |
| in_en | input | 1 | 1 = byte on in_byte is to be coded this cycle |
| idle_fill | input | 1 | 1 = send K28.5 when in_en is low |
| in_byte | input | 8 | Byte to code, [4:0] = x, [7:5] = y |
| ext_disp | input | 1 | External starting disparity, 1 = positive |
| ext_disp_sel | input | 1 | 1 = use ext_disp instead of the stored disparity |
| ctrl_err | output | 1 | Illegal control character in this word |
| code_out | output | 10 | Coded word, bit 9 = a, bit 0 = j |
| code_valid | output | 1 | code_out holds a coded word |
| disp_out | output | 1 | Running disparity after the word on code_out |
| disp_chain | output | 1 | Disparity after the word now in the coding stage |

## Verification
The hardest case to reach is the alternate D.x.7 form. It appears only for six byte values, and only when the disparity entering the 4-bit block has one particular sign. A plain data sweep therefore touches each case only at whatever disparity it happens to reach. The stimulus drives those six bytes with the disparity override set to both values, so both forms occur for every byte. A reference model compares the results on both latency builds, and a full sweep of control bytes covers every legal and illegal control code.

// File: rtl/enc8b10b_pkg.sv
// Package: shared widths, the idle byte and the negative-disparity code
// tables of the 8b/10b line code.
// Assumes: tables hold the form used when the entering disparity is negative.
package enc8b10b_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 10;
    localparam int SIX_W  = 6;
    localparam int FOUR_W = 4;
    localparam int X_W    = 5;
    localparam int Y_W    = 3;

    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hBC;   // K28.5
    localparam logic [X_W-1:0]    X_K28     = 5'd28;
    localparam logic [SIX_W-1:0]  K28_SIX   = 6'b001111;
    localparam logic [FOUR_W-1:0] ALT7_FOUR = 4'b0111;

    // One request as seen by the coding stage.
    typedef struct packed {
        logic              en;
        logic              idle;
        logic              ctrl;
        logic [BYTE_W-1:0] data;
        logic              frc;
        logic              disp;
    } enc_req_t;

    // 6-bit abcdei code of D.x at negative disparity.
    function automatic logic [SIX_W-1:0] six_neg(input logic [X_W-1:0] x);
        case (x)
            5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
            5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
            5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
            5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
            5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
            5'd10: return 6'b010101;  5'd11: return 6'b110100;
            5'd12: return 6'b001101;  5'd13: return 6'b101100;
            5'd14: return 6'b011100;  5'd15: return 6'b010111;
            5'd16: return 6'b011011;  5'd17: return 6'b100011;
            5'd18: return 6'b010011;  5'd19: return 6'b110010;
            5'd20: return 6'b001011;  5'd21: return 6'b101010;
            5'd22: return 6'b011010;  5'd23: return 6'b111010;
            5'd24: return 6'b110011;  5'd25: return 6'b100110;
            5'd26: return 6'b010110;  5'd27: return 6'b110110;
            5'd28: return 6'b001110;  5'd29: return 6'b101110;
            5'd30: return 6'b011110;  default: return 6'b101011;
        endcase
    endfunction

    // 4-bit fghj code of D.y at negative disparity (primary form for y=7).
    function automatic logic [FOUR_W-1:0] four_d_neg(input logic [Y_W-1:0] y);
        case (y)
            3'd0: return 4'b1011;  3'd1: return 4'b1001;
            3'd2: return 4'b0101;  3'd3: return 4'b1100;
            3'd4: return 4'b1101;  3'd5: return 4'b1010;
            3'd6: return 4'b0110;  default: return 4'b1110;
        endcase
    endfunction

    // 4-bit fghj code of K.y at negative disparity.
    function automatic logic [FOUR_W-1:0] four_k_neg(input logic [Y_W-1:0] y);
        case (y)
            3'd0: return 4'b1011;  3'd1: return 4'b0110;
            3'd2: return 4'b1010;  3'd3: return 4'b1100;
            3'd4: return 4'b1101;  3'd5: return 4'b0101;
            3'd6: return 4'b1001;  default: return 4'b0111;
        endcase
    endfunction

endpackage

// File: rtl/enc_kcheck.sv
// Control-character legality check.
// Does: reports whether a byte is one of the twelve legal control characters.
// Assumes: x = byte[4:0], y = byte[7:5]; purely combinational.
module enc_kcheck
    import enc8b10b_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic              legal
);
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;

    assign x = byte_in[X_W-1:0];
    assign y = byte_in[BYTE_W-1:X_W];

    // K28.y for any y, or Kx.7 for the four x values that allow it.
    always_comb begin
        legal = (x == X_K28) ||
                ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) ||
                                 (x == 5'd29) || (x == 5'd30)));
    end
endmodule

// File: rtl/enc_sub6.sv
// 5b/6b sub-block coder.
// Does: maps x to abcdei for the entering disparity and gives the
// disparity after the block.
// Assumes: k28 is set only for a legal K28.y; combinational.
module enc_sub6
    import enc8b10b_pkg::*;
(
    input  logic [X_W-1:0]   x,
    input  logic             k28,
    input  logic             rd_in,
    output logic [SIX_W-1:0] six,
    output logic             rd_mid
);
    logic [SIX_W-1:0] base;
    logic             unbal;
    logic             invert_ok;

    // Pick the negative-disparity form and decide whether a positive entry complements it.
    always_comb begin
        base      = k28 ? K28_SIX : six_neg(x);
        unbal     = ($countones(base) != 3);
        invert_ok = unbal || (!k28 && (x == 5'd7));
        six       = (rd_in && invert_ok) ? ~base : base;
        rd_mid    = rd_in ^ unbal;
    end
endmodule

// File: rtl/enc_sub4.sv
// 3b/4b sub-block coder.
// Does: maps y to fghj for the disparity left by the 6-bit block and picks
// the alternate y=7 form when the e and i bits would make a long run.
// Assumes: kmode is set only for a legal control character; combinational.
module enc_sub4
    import enc8b10b_pkg::*;
(
    input  logic [Y_W-1:0]    y,
    input  logic              kmode,
    input  logic              rd_mid,
    input  logic              e_bit,
    input  logic              i_bit,
    output logic [FOUR_W-1:0] four,
    output logic              rd_out
);
    logic              use_alt;
    logic [FOUR_W-1:0] base;
    logic              unbal;
    logic              invert_ok;

    // Choose the base code, then complement it for a positive entry where the code asks.
    always_comb begin
        use_alt   = (y == 3'd7) &&
                    ((!rd_mid && e_bit && i_bit) || (rd_mid && !e_bit && !i_bit));
        if (kmode)
            base = four_k_neg(y);
        else if (use_alt)
            base = ALT7_FOUR;
        else
            base = four_d_neg(y);
        unbal     = ($countones(base) != 2);
        invert_ok = kmode || unbal || (y == 3'd3);
        four      = (rd_mid && invert_ok) ? ~base : base;
        rd_out    = rd_mid ^ unbal;
    end
endmodule

// File: rtl/enc8b10b_top.sv
// 8b/10b line encoder with idle fill, disparity override and chain output.
// Does: optional input register, coding stage with the running-disparity
// register, optional output register (LONG_PIPE picks 3 or 1 cycles).
// Assumes: synchronous active-low reset; disparity 0 = negative.
module enc8b10b_top
    import enc8b10b_pkg::*;
#(
    parameter bit LONG_PIPE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_ctrl,
    input  logic              in_en,
    input  logic              idle_fill,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              ext_disp,
    input  logic              ext_disp_sel,
    output logic              ctrl_err,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              disp_out,
    output logic              disp_chain
);
    enc_req_t req_in;
    enc_req_t req_s;

    assign req_in = '{en: in_en, idle: idle_fill, ctrl: in_ctrl, data: in_byte,
                      frc: ext_disp_sel, disp: ext_disp};

    generate
        if (LONG_PIPE) begin : g_in_reg
            enc_req_t req_q;
            // Register the request for the long pipeline.
            always_ff @(posedge clk) begin
                if (!rst_n) req_q <= '0;
                else        req_q <= req_in;
            end
            assign req_s = req_q;
        end else begin : g_in_wire
            assign req_s = req_in;
        end
    endgenerate

    // ---------------- coding stage ----------------
    logic              word;
    logic [BYTE_W-1:0] sel_byte;
    logic              sel_ctrl;
    logic              legal;
    logic              k_ok;
    logic              bad_k;
    logic              rd_q;
    logic              cur_rd;
    logic [SIX_W-1:0]  six;
    logic [FOUR_W-1:0] four;
    logic              rd_mid;
    logic              rd_out;

    // Select the byte to code: offered byte, else the idle comma.
    always_comb begin
        word     = req_s.en || req_s.idle;
        sel_byte = req_s.en ? req_s.data : IDLE_BYTE;
        sel_ctrl = req_s.en ? req_s.ctrl : 1'b1;
        k_ok     = sel_ctrl && legal;
        bad_k    = req_s.en && req_s.ctrl && !legal;
        cur_rd   = req_s.frc ? req_s.disp : rd_q;
    end

    enc_kcheck u_kcheck (
        .byte_in (sel_byte),
        .legal   (legal)
    );

    enc_sub6 u_sub6 (
        .x      (sel_byte[X_W-1:0]),
        .k28    (k_ok && (sel_byte[X_W-1:0] == X_K28)),
        .rd_in  (cur_rd),
        .six    (six),
        .rd_mid (rd_mid)
    );

    enc_sub4 u_sub4 (
        .y      (sel_byte[BYTE_W-1:X_W]),
        .kmode  (k_ok),
        .rd_mid (rd_mid),
        .e_bit  (six[1]),
        .i_bit  (six[0]),
        .four   (four),
        .rd_out (rd_out)
    );

    assign disp_chain = word ? rd_out : cur_rd;

    logic [CODE_W-1:0] code_b;
    logic              valid_b;
    logic              err_b;

    // Capture the coded word and update the stored disparity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_b  <= '0;
            valid_b <= 1'b0;
            err_b   <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            code_b  <= word ? {six, four} : '0;
            valid_b <= word;
            err_b   <= bad_k;
            if (word) rd_q <= rd_out;
        end
    end

    // Idle request yields one of the two K28.5 forms (R6).
    p_idle_comma_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_s.en && req_s.idle) |=> (code_b == 10'h0FA || code_b == 10'h305));
    // An error flag only travels with a coded word (R5).
    p_err_with_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_b |-> valid_b);
    // No request: stored disparity holds (R7).
    p_hold_disp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !word |=> $stable(rd_q));
    // Empty slot carries an all-zero word (R7).
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_b |-> (code_b == '0));
    // Word weight stays within one of balance (R3).
    p_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_b |-> ($countones(code_b) >= 4 && $countones(code_b) <= 6));
    // Balanced word keeps the disparity, unbalanced flips it (R3).
    p_neutral_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word |=> (($countones(code_b) == 5) == (rd_q == $past(cur_rd))));
    // A heavy word leaves positive disparity (R9).
    p_heavy_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_b && $countones(code_b) == 6) |-> rd_q);

    // ---------------- output stage ----------------
    generate
        if (LONG_PIPE) begin : g_out_reg
            logic [CODE_W-1:0] code_c;
            logic              valid_c;
            logic              err_c;
            logic              disp_c;
            // Register the outputs for the long pipeline.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    code_c  <= '0;
                    valid_c <= 1'b0;
                    err_c   <= 1'b0;
                    disp_c  <= 1'b0;
                end else begin
                    code_c  <= code_b;
                    valid_c <= valid_b;
                    err_c   <= err_b;
                    disp_c  <= rd_q;
                end
            end
            assign code_out   = code_c;
            assign code_valid = valid_c;
            assign ctrl_err   = err_c;
            assign disp_out   = disp_c;
        end else begin : g_out_wire
            assign code_out   = code_b;
            assign code_valid = valid_b;
            assign ctrl_err   = err_b;
            assign disp_out   = rd_q;
        end
    endgenerate
endmodule

// File: tb/tb_enc8b10b_top.sv
`timescale 1ns/1ps
module tb_enc8b10b_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       rst_n = 1'b0;
    logic       in_ctrl = 0, in_en = 0, idle_fill = 0, ext_disp = 0, ext_disp_sel = 0;
    logic [7:0] in_byte = 8'h00;

    logic       l_err, l_vld, l_disp, l_chain;
    logic [9:0] l_code;
    logic       s_err, s_vld, s_disp, s_chain;
    logic [9:0] s_code;

    enc8b10b_top #(.LONG_PIPE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_ctrl(in_ctrl), .in_en(in_en),
        .idle_fill(idle_fill), .in_byte(in_byte), .ext_disp(ext_disp),
        .ext_disp_sel(ext_disp_sel), .ctrl_err(l_err), .code_out(l_code),
        .code_valid(l_vld), .disp_out(l_disp), .disp_chain(l_chain));

    enc8b10b_top #(.LONG_PIPE(1'b0)) dut_fast (
        .clk(clk), .rst_n(rst_n), .in_ctrl(in_ctrl), .in_en(in_en),
        .idle_fill(idle_fill), .in_byte(in_byte), .ext_disp(ext_disp),
        .ext_disp_sel(ext_disp_sel), .ctrl_err(s_err), .code_out(s_code),
        .code_valid(s_vld), .disp_out(s_disp), .disp_chain(s_chain));

    typedef struct {
        logic       vld;
        logic       err;
        logic [9:0] code;
        logic       rd;
        logic       chain;
        string      rq;
    } exp_t;

    exp_t q_long[$];
    exp_t q_short[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic ref_rd = 1'b0;
    logic chain_long_exp = 1'b0;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    // Reference tables written as negative-disparity forms plus balance lists.
    function automatic logic [5:0] ref6(input int x);
        logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
                               6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
                               6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
                               6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
                               6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
                               6'b011110, 6'b101011};
        return t[x];
    endfunction

    function automatic exp_t model(input logic en, input logic idle, input logic ctrl,
                                   input logic [7:0] d, input logic frc, input logic dv,
                                   input string rq);
        exp_t       e;
        logic       start, mid;
        logic [7:0] b;
        logic       k, legal, kk;
        int         x, y, n;
        logic [5:0] s6;
        logic [3:0] f4;
        logic [3:0] dneg [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
        logic [3:0] kneg [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100, 4'b1101, 4'b0101, 4'b1001, 4'b0111};
        e.rq  = rq;
        start = frc ? dv : ref_rd;
        if (!en && !idle) begin
            e.vld = 0; e.err = 0; e.code = '0; e.rd = ref_rd; e.chain = start;
            return e;
        end
        b     = en ? d : 8'hBC;
        k     = en ? ctrl : 1'b1;
        legal = (b[4:0] == 5'd28) || b == 8'hF7 || b == 8'hFB || b == 8'hFD || b == 8'hFE;
        kk    = k && legal;
        x = int'(b[4:0]); y = int'(b[7:5]);
        if (kk && x == 28) s6 = start ? 6'b110000 : 6'b001111;
        else if (x inside {3,5,6,9,10,11,12,13,14,17,18,19,20,21,22,25,26,28}) s6 = ref6(x);
        else s6 = start ? ~ref6(x) : ref6(x);
        n   = $countones(s6);
        mid = (n > 3) ? 1'b1 : (n < 3) ? 1'b0 : start;
        if (kk) f4 = mid ? ~kneg[y] : kneg[y];
        else if (y == 7 && ((!mid && x inside {17,18,20}) || (mid && x inside {11,13,14})))
            f4 = mid ? 4'b1000 : 4'b0111;
        else if (y inside {1,2,5,6}) f4 = dneg[y];
        else f4 = mid ? ~dneg[y] : dneg[y];
        e.code  = {s6, f4};
        n       = $countones(e.code);
        e.rd    = (n > 5) ? 1'b1 : (n < 5) ? 1'b0 : start;
        e.chain = e.rd;
        e.vld   = 1'b1;
        e.err   = en && ctrl && !legal;
        ref_rd  = e.rd;
        return e;
    endfunction

    task automatic cmp_out(input exp_t o, input string path, input logic [9:0] code,
                           input logic vld, input logic err, input logic disp);
        chk(o.rq, {path, " code_out"}, 32'(code), 32'(o.code));
        chk(o.vld ? o.rq : "R7", {path, " code_valid"}, 32'(vld), 32'(o.vld));
        chk("R5", {path, " ctrl_err"}, 32'(err), 32'(o.err));
        chk("R9", {path, " disp_out"}, 32'(disp), 32'(o.rd));
    endtask

    // One cycle: compare what is due, then drive the next request.
    task automatic step(input logic en, input logic idle, input logic ctrl, input logic [7:0] d,
                        input logic frc, input logic dv, input string rq);
        exp_t e, o;
        @(negedge clk);
        if (q_long.size() >= 3) begin
            o = q_long.pop_front();
            cmp_out(o, "R11 long", l_code, l_vld, l_err, l_disp);
        end
        if (q_short.size() >= 1) begin
            o = q_short.pop_front();
            cmp_out(o, "R11 short", s_code, s_vld, s_err, s_disp);
        end
        chk("R10", "long disp_chain", 32'(l_chain), 32'(chain_long_exp));
        in_en = en; idle_fill = idle; in_ctrl = ctrl; in_byte = d;
        ext_disp_sel = frc; ext_disp = dv;
        e = model(en, idle, ctrl, d, frc, dv, rq);
        q_long.push_back(e);
        q_short.push_back(e);
        chain_long_exp = e.chain;
        #1;
        chk("R10", "short disp_chain", 32'(s_chain), 32'(e.chain));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state on both builds
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R1", "long code_out", 32'(l_code), 0);
                chk("R1", "long code_valid", 32'(l_vld), 0);
                chk("R1", "long ctrl_err", 32'(l_err), 0);
                chk("R1", "long disp_out", 32'(l_disp), 0);
                chk("R1", "short code_out", 32'(s_code), 0);
                chk("R1", "short disp_out", 32'(s_disp), 0);
            end
        end
        rst_n = 1'b1;

        // R6: first idle after reset at negative disparity
        step(0, 1, 0, 8'h00, 0, 0, "R6");
        step(0, 1, 0, 8'h00, 0, 0, "R6");
        // R2: every data byte
        for (int v = 0; v < 256; v++) step(1, 0, 0, 8'(v), 0, 0, "R2");
        // R4 / R5: every byte flagged as control
        for (int v = 0; v < 256; v++) begin
            logic [7:0] bv;
            bv = 8'(v);
            step(1, 0, 1, bv, 0, 0,
                 ((bv[4:0] == 5'd28) || bv == 8'hF7 || bv == 8'hFB || bv == 8'hFD || bv == 8'hFE) ? "R4" : "R5");
        end
        // R6 / R7: idle fill, then empty slots with the disparity held
        for (int i = 0; i < 6; i++) step(0, 1, 0, 8'h55, 0, 0, "R6");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 8'h3C, 0, 0, "R7");
        step(0, 1, 0, 8'h00, 0, 0, "R6");
        // R3: alternate D.x.7 forms forced at both disparities
        foreach (q_long[i]) ; // no-op keeps queues untouched
        for (int s = 0; s < 2; s++) begin
            for (int j = 0; j < 6; j++) begin
                int xs [6] = '{11, 13, 14, 17, 18, 20};
                step(1, 0, 0, {3'd7, 5'(xs[j])}, 1, 1'(s), "R3");
            end
        end
        // R8: override with varied values, including on empty and idle slots
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[2], r[3] & r[4], r[15:8], 1, r[5], "R8");
        end
        // R3: random mix of everything
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[2:0] < 3'd5, r[3], r[6:4] == 3'd0, r[15:8], r[20:17] == 4'd0, r[21], "R3");
        end
        // drain the pipelines with empty slots
        for (int i = 0; i < 5; i++) step(0, 0, 0, 8'h00, 0, 0, "R7");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule